// File: doc/BRIEF.md
# I2C Control-Register Target with Auto-Increment

This block is an I2C target that exposes a bank of 8-bit control registers, addressed by an 8-bit register pointer. A master writes by sending the device address with the direction bit clear, one register address byte, and then as many data bytes as it wants. The first data byte lands at the given address and each later byte at the next higher one. A read returns bytes starting at the current pointer, which also steps forward after every byte. The pointer survives a STOP, so a master can set it in one transfer and read from it in the next, or use a repeated START.

SCL and SDA are sampled by a faster system clock through two-flop synchronizers. START and STOP are found as SDA edges while SCL is high. The target drives SDA only in open-drain fashion: `sda_pull_o` high means pull the line low. All register contents are presented in parallel for the surrounding control logic. The bus has no flow control beyond I2C's own ACK/NACK. There is no valid/ready stream at this block's edge, and the target never stretches SCL.

Top module: `i2c_regbank_target`

## Requirements
- R1: After reset every register reads 0x00, the pointer is 0 and SDA is released.
- R2: An address byte whose upper seven bits equal DEV_ADDR is acknowledged, and its least significant bit selects read (1) or write (0). A byte with another address is not acknowledged, and the target ignores the bus until the next START.
- R3: In a write, the byte after the address is the register address. It is always acknowledged and loads the pointer.
- R4: Each following data byte is acknowledged and stored at the pointer, and the pointer then advances by one.
- R5: Once a byte has been stored in register NUM_REGS-1, the pointer holds there. Further data bytes are neither acknowledged nor stored until a new register address is given.
- R6: A register address of NUM_REGS or above is acknowledged. Data bytes written after it are neither acknowledged nor stored, and reads return 0xFF.
- R7: A read sends the byte at the pointer MSB first, and the pointer advances after each byte. A read made after register NUM_REGS-1 has been passed returns 0xFF.
- R8: A master NACK after a read byte ends the read. SDA is released and further SCL pulses are ignored until a START.
- R9: A repeated START begins a new address phase without a STOP, and the pointer keeps its value.
- R10: A STOP at any point returns the target to idle with SDA released. The pointer is kept for the next transfer.
- R11: A START in the middle of a byte abandons that byte. Nothing from it is stored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level (wired bus value) |
| sda_pull_o | output | 1 | 1 = pull SDA low (open-drain enable) |
| ctrl_regs_o | output | NUM_REGS*8 | All registers; register i at bits [8i+7:8i] |

## Verification
The bench attacks the end of the register space. It writes across register NUM_REGS-1 and reads beyond it, so a design that wraps to 0 would overwrite register 0, and one that acknowledges past the end would show up in the ACK value. It runs a combined write-then-repeated-START-read and also reads after a STOP. A design that resets the pointer on either event returns the wrong first byte. It sends a START in the middle of a data byte and clocks the bus after a master NACK. A design that stores partial bytes, or keeps driving SDA after a NACK, changes the register image or answers with an ACK where none may appear.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;
  localparam int PTR_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_RX_ACK,
    ST_TX,
    ST_TX_ACK
  } tgt_state_e;

  typedef enum logic [1:0] {
    PH_DEVADDR,
    PH_REGADDR,
    PH_WDATA
  } rx_phase_e;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [SYNC_STAGES-1:0] scl_q, sda_q;
  logic scl_d, sda_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= '1;
      sda_q <= '1;
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_q <= {scl_q[SYNC_STAGES-2:0], scl_i};
      sda_q <= {sda_q[SYNC_STAGES-2:0], sda_i};
      scl_d <= scl_q[SYNC_STAGES-1];
      sda_d <= sda_q[SYNC_STAGES-1];
    end
  end

  assign scl_s     = scl_q[SYNC_STAGES-1];
  assign sda_s     = sda_q[SYNC_STAGES-1];
  assign scl_rise  = scl_s & ~scl_d;
  assign scl_fall  = ~scl_s & scl_d;
  // SDA edge while SCL stays high
  assign start_det = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_det  = scl_s & scl_d & ~sda_d & sda_s;
endmodule

// File: rtl/i2c_reg_bank.sv
module i2c_reg_bank #(
  parameter int NUM_REGS = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [7:0]            wr_addr,
  input  logic [7:0]            wr_data,
  input  logic [7:0]            rd_addr,
  output logic [7:0]            rd_data,
  output logic [NUM_REGS*8-1:0] regs_o
);
  localparam int IDX_W = $clog2(NUM_REGS);
  localparam logic [8:0] NREG9 = 9'(NUM_REGS);

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    logic [7:0] q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          q <= 8'h00;
      else if (wr_en && wr_addr == 8'(i))  q <= wr_data;
    end
    assign regs_o[i*8 +: 8] = q;
  end

  always_comb begin
    if ({1'b0, rd_addr} < NREG9) rd_data = regs_o[{rd_addr[IDX_W-1:0], 3'b000} +: 8];
    else                          rd_data = 8'h00;
  end

  // R5
  wr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> ({1'b0, wr_addr} < NREG9));
endmodule

// File: rtl/i2c_tgt_fsm.sv
module i2c_tgt_fsm
  import i2c_tgt_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h3C,
  parameter int         NUM_REGS = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_s,
  input  logic       sda_s,
  input  logic       scl_rise,
  input  logic       scl_fall,
  input  logic       start_det,
  input  logic       stop_det,
  output logic       wr_en,
  output logic [7:0] wr_addr,
  output logic [7:0] wr_data,
  output logic [7:0] rd_addr,
  input  logic [7:0] rd_data,
  output logic       sda_pull
);
  localparam logic [8:0]       NREG9    = 9'(NUM_REGS);
  localparam logic [PTR_W-1:0] LAST_IDX = PTR_W'(NUM_REGS - 1);

  tgt_state_e       state;
  rx_phase_e        phase;
  logic [3:0]       cnt;
  logic [7:0]       shreg, txsh;
  logic [PTR_W-1:0] ptr;
  logic             oor, rw, mack;
  logic [7:0]       rd_byte;

  assign rd_addr = ptr;
  assign rd_byte = oor ? 8'hFF : rd_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;  phase <= PH_DEVADDR;
      cnt <= '0;  shreg <= '0;  txsh <= '0;
      ptr <= '0;  oor <= 1'b0;  rw <= 1'b0;  mack <= 1'b0;
      sda_pull <= 1'b0;  wr_en <= 1'b0;
      wr_addr <= '0;  wr_data <= '0;
    end else begin
      wr_en <= 1'b0;
      if (stop_det) begin
        state <= ST_IDLE;
        sda_pull <= 1'b0;
      end else if (start_det) begin
        state <= ST_RX;  phase <= PH_DEVADDR;
        cnt <= '0;  sda_pull <= 1'b0;
      end else begin
        unique case (state)
          ST_RX: begin
            if (scl_rise && cnt != 4'd8) begin
              shreg <= {shreg[6:0], sda_s};
              cnt   <= cnt + 4'd1;
            end else if (scl_fall && cnt == 4'd8) begin
              cnt   <= '0;
              state <= ST_RX_ACK;
              unique case (phase)
                PH_DEVADDR: begin
                  if (shreg[7:1] == DEV_ADDR) begin
                    sda_pull <= 1'b1;
                    rw       <= shreg[0];
                  end else begin
                    state <= ST_IDLE;
                  end
                end
                PH_REGADDR: begin
                  ptr      <= shreg;
                  oor      <= ({1'b0, shreg} >= NREG9);
                  sda_pull <= 1'b1;
                end
                default: begin
                  if (!oor) begin
                    sda_pull <= 1'b1;
                    wr_en    <= 1'b1;
                    wr_addr  <= ptr;
                    wr_data  <= shreg;
                    if (ptr == LAST_IDX) oor <= 1'b1;
                    else                 ptr <= ptr + 1'b1;
                  end
                end
              endcase
            end
          end
          ST_RX_ACK: begin
            if (scl_fall) begin
              cnt <= '0;
              if (phase == PH_DEVADDR && rw) begin
                state    <= ST_TX;
                txsh     <= rd_byte;
                sda_pull <= ~rd_byte[7];
              end else begin
                state    <= ST_RX;
                sda_pull <= 1'b0;
                phase    <= (phase == PH_DEVADDR) ? PH_REGADDR : PH_WDATA;
              end
            end
          end
          ST_TX: begin
            if (scl_fall) begin
              if (cnt == 4'd7) begin
                state    <= ST_TX_ACK;
                sda_pull <= 1'b0;
                if (!oor) begin
                  if (ptr == LAST_IDX) oor <= 1'b1;
                  else                 ptr <= ptr + 1'b1;
                end
              end else begin
                cnt      <= cnt + 4'd1;
                txsh     <= {txsh[6:0], 1'b0};
                sda_pull <= ~txsh[6];
              end
            end
          end
          ST_TX_ACK: begin
            if (scl_rise) mack <= ~sda_s;
            else if (scl_fall) begin
              if (mack) begin
                state    <= ST_TX;
                cnt      <= '0;
                txsh     <= rd_byte;
                sda_pull <= ~rd_byte[7];
              end else begin
                state <= ST_IDLE;
              end
            end
          end
          default: sda_pull <= 1'b0;
        endcase
      end
    end
  end

  // R4
  ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (oor || ptr == wr_addr + 8'd1));
  // R10
  stop_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> (!sda_pull && state == ST_IDLE));
  // R11
  start_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> (cnt == 4'd0 && !sda_pull && !wr_en));
  // R2
  drive_low_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_pull) |-> !scl_s);
  // R8
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE && !start_det) |=> !sda_pull);
endmodule

// File: rtl/i2c_regbank_target.sv
module i2c_regbank_target #(
  parameter logic [6:0] DEV_ADDR    = 7'h3C,
  parameter int         NUM_REGS    = 16,
  parameter int         SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  scl_i,
  input  logic                  sda_i,
  output logic                  sda_pull_o,
  output logic [NUM_REGS*8-1:0] ctrl_regs_o
);
  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic wr_en;
  logic [7:0] wr_addr, wr_data, rd_addr, rd_data;

  i2c_line_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  i2c_tgt_fsm #(.DEV_ADDR(DEV_ADDR), .NUM_REGS(NUM_REGS)) u_fsm (
    .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .sda_pull(sda_pull_o)
  );

  i2c_reg_bank #(.NUM_REGS(NUM_REGS)) u_bank (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .regs_o(ctrl_regs_o)
  );
endmodule

// File: tb/sim_i2c_regbank_target.sv
`timescale 1ns/1ps
module sim_i2c_regbank_target;
  localparam int NREG = 16;
  localparam logic [6:0] DEV = 7'h3C;
  localparam int Q = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic sda_pull;
  logic [NREG*8-1:0] regs;
  wire sda_bus = sda_m & ~sda_pull;

  int n_chk = 0, n_err = 0;
  bit cmp_en = 1'b0;
  int mreg [NREG];
  int mptr = 0;
  bit moor = 1'b0;

  always #4 clk = ~clk;

  i2c_regbank_target #(.DEV_ADDR(DEV), .NUM_REGS(NREG)) u0 (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus),
    .sda_pull_o(sda_pull), .ctrl_regs_o(regs)
  );

  function automatic logic [NREG*8-1:0] model_vec();
    logic [NREG*8-1:0] v;
    for (int i = 0; i < NREG; i++) v[i*8 +: 8] = 8'(mreg[i]);
    return v;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s act %0h exp %0h", req, what, act, exp);
    end
  endtask

  // per-clock comparison of the register image against the model (R4 R5 R6 R11)
  always @(negedge clk) begin
    if (cmp_en && rst_n) begin
      n_chk++;
      if (regs !== model_vec()) begin
        n_err++;
        if (n_err < 12) $display("FAIL R4 R5 R11 register image act %h exp %h", regs, model_vec());
      end
    end
  end

  task automatic hq; repeat (Q) @(negedge clk); endtask
  task automatic bus_start;  sda_m = 1; scl_m = 1; hq; sda_m = 0; hq; scl_m = 0; hq; endtask
  task automatic bus_rstart; sda_m = 1; hq; scl_m = 1; hq; sda_m = 0; hq; scl_m = 0; hq; endtask
  task automatic bus_stop;   sda_m = 0; hq; scl_m = 1; hq; sda_m = 1; hq; endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    cmp_en = 0;
    for (int i = 7; i > 7 - n; i--) begin
      sda_m = b[i]; hq; scl_m = 1; hq; hq; scl_m = 0; hq;
    end
  endtask

  task automatic send_byte(input logic [7:0] b, output bit ack);
    send_bits(b, 8);
    sda_m = 1; hq; scl_m = 1; hq; ack = ~sda_bus; hq; scl_m = 0; hq;
  endtask

  task automatic recv_byte(output logic [7:0] b, input bit give_ack);
    b = '0;
    sda_m = 1;
    for (int i = 0; i < 8; i++) begin
      hq; scl_m = 1; hq; b = {b[6:0], sda_bus}; hq; scl_m = 0;
    end
    hq; sda_m = ~give_ack; hq; scl_m = 1; hq; hq; scl_m = 0; hq; sda_m = 1;
  endtask

  // model: data byte written
  task automatic m_wr(input logic [7:0] b, output bit exp_ack);
    exp_ack = !moor;
    if (!moor) begin
      mreg[mptr] = b;
      if (mptr == NREG - 1) moor = 1; else mptr++;
    end
  endtask
  task automatic m_rd(output int exp);
    exp = moor ? 8'hFF : mreg[mptr];
    if (!moor) begin
      if (mptr == NREG - 1) moor = 1; else mptr++;
    end
  endtask
  task automatic m_ptr(input logic [7:0] a);
    mptr = a; moor = (a >= NREG);
  endtask

  task automatic wr_data(input logic [7:0] b, input string req);
    bit a, ea;
    send_byte(b, a);
    m_wr(b, ea);
    cmp_en = 1;
    chk(a == ea, req, "data ack", a, ea);
  endtask
  task automatic addr_phase(input bit rd, input bit exp_ack, input string req);
    bit a;
    send_byte({DEV, rd}, a);
    cmp_en = 1;
    chk(a == exp_ack, req, "address ack", a, exp_ack);
  endtask
  task automatic reg_phase(input logic [7:0] r, input string req);
    bit a;
    send_byte(r, a);
    m_ptr(r);
    cmp_en = 1;
    chk(a == 1'b1, req, "register address ack", a, 1);
  endtask
  task automatic rd_data(input bit give_ack, input string req);
    logic [7:0] b; int e;
    recv_byte(b, give_ack);
    m_rd(e);
    chk(int'(b) == e, req, "read data", b, e);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin : stim
    bit a;
    for (int i = 0; i < NREG; i++) mreg[i] = 0;
    repeat (5) @(negedge clk);
    rst_n = 1;
    repeat (5) @(negedge clk);
    // R1 reset state
    chk(regs == '0, "R1", "regs after reset", int'(regs[31:0]), 0);
    chk(sda_pull == 1'b0, "R1", "sda released", sda_pull, 0);
    cmp_en = 1;

    // R3 R4 burst write
    bus_start; addr_phase(0, 1, "R2"); reg_phase(8'd2, "R3");
    wr_data(8'hA1, "R4"); wr_data(8'hB2, "R4"); wr_data(8'hC3, "R4");
    bus_stop; hq;
    chk(regs[3*8 +: 8] == 8'hB2, "R4", "reg3", regs[3*8 +: 8], 8'hB2);
    chk(sda_pull == 1'b0, "R10", "released after stop", sda_pull, 0);

    // R2 wrong address ignored
    bus_start; send_byte({7'h11, 1'b0}, a); cmp_en = 1;
    chk(a == 0, "R2", "foreign address ack", a, 0);
    send_byte(8'h00, a); cmp_en = 1;
    chk(a == 0, "R2", "byte after foreign address", a, 0);
    bus_stop;
    chk(regs[0 +: 8] == 8'h00, "R2", "reg0 untouched", regs[0 +: 8], 0);

    // R5 clamp at end
    bus_start; addr_phase(0, 1, "R2"); reg_phase(8'(NREG - 2), "R3");
    wr_data(8'h11, "R5"); wr_data(8'h22, "R5"); wr_data(8'h33, "R5");
    bus_stop;
    chk(regs[(NREG-1)*8 +: 8] == 8'h22, "R5", "last reg", regs[(NREG-1)*8 +: 8], 8'h22);
    chk(regs[0 +: 8] == 8'h00, "R5", "no wrap to reg0", regs[0 +: 8], 0);

    // R5 R7 read after end returns FF
    bus_start; addr_phase(1, 1, "R2"); rd_data(0, "R7"); bus_stop;

    // R9 R7 R8 combined transfer with repeated START
    bus_start; addr_phase(0, 1, "R2"); reg_phase(8'd2, "R3");
    bus_rstart; addr_phase(1, 1, "R9");
    rd_data(1, "R7"); rd_data(1, "R7"); rd_data(0, "R8");
    hq;
    chk(sda_pull == 1'b0, "R8", "released after NACK", sda_pull, 0);
    send_byte(8'h00, a); cmp_en = 1;
    chk(a == 0, "R8", "clocks after NACK ignored", a, 0);
    bus_stop;

    // R6 out-of-range register address
    bus_start; addr_phase(0, 1, "R2"); reg_phase(8'hF0, "R6");
    wr_data(8'h55, "R6");
    bus_rstart; addr_phase(1, 1, "R9"); rd_data(0, "R6"); bus_stop;

    // R10 pointer kept across STOP
    bus_start; addr_phase(0, 1, "R2"); reg_phase(8'd3, "R3"); bus_stop;
    bus_start; addr_phase(1, 1, "R10"); rd_data(1, "R10"); rd_data(0, "R10"); bus_stop;

    // R11 START inside a data byte
    bus_start; addr_phase(0, 1, "R2"); reg_phase(8'd7, "R3");
    send_bits(8'hFF, 5);
    bus_rstart; cmp_en = 1; addr_phase(0, 1, "R11");
    bus_stop;
    chk(regs[7*8 +: 8] == 8'h00, "R11", "reg7 after aborted byte", regs[7*8 +: 8], 0);
    bus_start; addr_phase(1, 1, "R11"); rd_data(0, "R11"); bus_stop;

    // R7 read across last register
    bus_start; addr_phase(0, 1, "R2"); reg_phase(8'(NREG - 1), "R3");
    bus_rstart; addr_phase(1, 1, "R9"); rd_data(1, "R7"); rd_data(0, "R7"); bus_stop;

    hq;
    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule